// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller

This block gathers sixteen asynchronous interrupt lines into one interrupt request for a processor. Each line passes through a synchronizer. A rising edge on the synchronized line latches a pending bit. The level of the line does not set the bit, so a line held high raises at most one event per rising transition. A mask register selects which pending bits may drive the request line. A bit value of one in the mask blocks that input and a value of zero lets it through.

Software reaches the block through a small synchronous register port: a word address, a write enable, write data and registered read data. The pending register clears by writing zeros. A zero clears the bit in that position and a one leaves it as it is, so software acknowledges one source by writing the inverse of its bit. When a new edge arrives in the same cycle as the write that clears its bit, the edge wins and the event is kept. After reset every input is masked until software programs the mask.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the pending register reads 0x0000, the mask register reads 0xFFFF, and `irq_req` is low.
- R2: The mask register sits at word address 0xA. A write there stores all 16 bits, and a read returns them one cycle after the address is presented.
- R3: The pending register sits at word address 0x2. A read returns every latched pending bit, masked or not. Bit n belongs to input n.
- R4: A low-to-high transition on `irq_in[n]` sets pending bit n. A line that stays high does not set the bit again after it has been cleared, and a falling transition sets nothing.
- R5: A write to address 0x2 clears each pending bit written as 0 and keeps each bit written as 1, so writing 0xFFFF changes nothing.
- R6: When a rising edge on input n is detected in the same cycle as a write that clears pending bit n, bit n stays set. Other bits cleared by that write still clear.
- R7: `irq_req` is a register. It goes high one clock after some bit of (pending AND NOT mask) is 1, and it goes low one clock after no such bit remains.
- R8: A read of any address other than 0x2 and 0xA returns zero. A write to any such address changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 4 | Word address of the register access |
| reg_we | input | 1 | Write enable for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the address of the previous cycle |
| irq_in | input | 16 | Raw interrupt lines, asynchronous |
| irq_req | output | 1 | Combined interrupt request to the processor |

## Verification
The bench sweeps every input position. For each one it checks that a pulse sets only its own pending bit, that the pulse cannot raise the request while its mask bit is set, and that the request follows the mask one clock late. A design with inverted mask polarity, or with a combinational output, fails on the first input. The bench times a clearing write to land in the exact cycle a new edge is detected. A design that lets the write win drops that event. The bench also holds a line high across a clear. A design that latches the level brings the bit straight back. Further checks write 0xFFFF to the pending register and write to every unmapped address, and catch a decoder that clears bits it should keep or that aliases addresses.

// File: rtl/irqc_pkg.sv
// Package: irqc_pkg
// Shared constants and types of the edge-triggered interrupt controller.
// Assumes word addressing on a 4-bit register address.
package irqc_pkg;

    localparam int unsigned IRQC_ADDR_W = 4;

    // Word addresses of the two registers
    localparam logic [IRQC_ADDR_W-1:0] IRQC_OFS_PEND = 4'h2;
    localparam logic [IRQC_ADDR_W-1:0] IRQC_OFS_MASK = 4'hA;

    // Decoded register select
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2
    } irqc_sel_e;

endpackage

// File: rtl/irqc_edge_detect.sv
// Module: irqc_edge_detect
// Brings N asynchronous lines into the clock domain through a chain of
// STAGES flops per line, then flags a rising edge for one cycle by
// comparing the last stage with its previous sample.
// Assumes each input pulse lasts at least STAGES+1 clock cycles.
module irqc_edge_detect #(
    parameter int unsigned N      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] rise
);

    localparam int unsigned LAST = STAGES - 1;

    logic [N-1:0] sync_q [STAGES];
    logic [N-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw lines
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= '0;
                    else        sync_q[0] <= raw_in;
                end
            end else begin : g_next
                // Later stages shift the sampled value along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= '0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // Hold the previous synchronized value for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q[LAST];
    end

    // A bit is newly high when the synchronized line is high and was low
    always_comb begin
        rise = sync_q[LAST] & ~prev_q;
    end

    // R4: an edge indication never lasts two cycles in a row
    rise_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & $past(rise)) == '0);

endmodule

// File: rtl/irqc_pending.sv
// Module: irqc_pending
// Holds the N pending bits. A detected edge sets a bit. A clear write
// clears the bits written as zero, and an edge in the same cycle wins.
// Assumes clr_we is high for one cycle per software write.
module irqc_pending #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise,
    input  logic         clr_we,
    input  logic [N-1:0] clr_keep,
    output logic [N-1:0] pend_q
);

    logic [N-1:0] kept;

    // Bits that survive this cycle's write, if any
    always_comb begin
        kept = clr_we ? (pend_q & clr_keep) : pend_q;
    end

    // Latch new edges on top of the surviving bits
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= kept | rise;
    end

    // R6: a detected edge is always visible as pending in the next cycle
    edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rise) & ~pend_q) == '0);

    // R5: after a clear write, a bit written as zero holds only if an edge set it
    zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_we) |-> ((pend_q & ~$past(clr_keep) & ~$past(rise)) == '0));

    // R4: a bit never rises without an edge having been detected
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(rise)) == '0);

endmodule

// File: rtl/irqc_regs.sv
// Module: irqc_regs
// Decodes the register port. It keeps the mask register, produces the
// clear strobe for the pending bits and registers the read data.
// Unmapped addresses read as zero and ignore writes.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned       N          = 16,
    parameter int unsigned       ADDR_W     = IRQC_ADDR_W,
    parameter logic [N-1:0]      RESET_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      pend_q,
    output logic [N-1:0]      mask_q,
    output logic              pend_clr_we,
    output logic [N-1:0]      rdata
);

    irqc_sel_e sel;

    // Map the word address onto a register select
    always_comb begin
        if (addr == ADDR_W'(IRQC_OFS_PEND))      sel = SEL_PEND;
        else if (addr == ADDR_W'(IRQC_OFS_MASK)) sel = SEL_MASK;
        else                                     sel = SEL_NONE;
    end

    // Strobe the clear path only for writes to the pending register
    always_comb begin
        pend_clr_we = we && (sel == SEL_PEND);
    end

    // Store the mask on writes to its address
    always_ff @(posedge clk) begin
        if (!rst_n)                      mask_q <= RESET_MASK;
        else if (we && sel == SEL_MASK)  mask_q <= wdata;
    end

    // Register the read data for the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            unique case (sel)
                SEL_PEND: rdata <= pend_q;
                SEL_MASK: rdata <= mask_q;
                default:  rdata <= '0;
            endcase
        end
    end

    // R1: the mask leaves reset with all inputs blocked
    mask_reset_chk: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (mask_q == RESET_MASK));

    // R8: the mask never changes except on a write to its own address
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we && addr == ADDR_W'(IRQC_OFS_MASK)) |-> $stable(mask_q));

    // R8: unmapped addresses return zero one cycle later
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr) != ADDR_W'(IRQC_OFS_PEND) && $past(addr) != ADDR_W'(IRQC_OFS_MASK))
        |-> (rdata == '0));

endmodule

// File: rtl/edge_irq_ctrl.sv
// Module: edge_irq_ctrl
// Top of the edge-triggered interrupt controller. It joins the edge
// detector, the pending bits and the register decoder, and drives a
// registered request from the unmasked pending bits.
// Assumes one clock domain; irq_in may be asynchronous.
module edge_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned  N_IN        = 16,
    parameter int unsigned  SYNC_STAGES = 2,
    parameter int unsigned  ADDR_W      = IRQC_ADDR_W,
    parameter logic [N_IN-1:0] RESET_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [N_IN-1:0]   reg_wdata,
    output logic [N_IN-1:0]   reg_rdata,
    input  logic [N_IN-1:0]   irq_in,
    output logic              irq_req
);

    logic [N_IN-1:0] rise;
    logic [N_IN-1:0] pend_q;
    logic [N_IN-1:0] mask_q;
    logic            pend_clr_we;
    logic            any_live;

    irqc_edge_detect #(
        .N      (N_IN),
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (irq_in),
        .rise   (rise)
    );

    irqc_pending #(
        .N (N_IN)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .clr_we   (pend_clr_we),
        .clr_keep (reg_wdata),
        .pend_q   (pend_q)
    );

    irqc_regs #(
        .N          (N_IN),
        .ADDR_W     (ADDR_W),
        .RESET_MASK (RESET_MASK)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .pend_q      (pend_q),
        .mask_q      (mask_q),
        .pend_clr_we (pend_clr_we),
        .rdata       (reg_rdata)
    );

    // Any pending bit whose mask bit is zero asks for service
    always_comb begin
        any_live = |(pend_q & ~mask_q);
    end

    // Register the request line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= any_live;
    end

    // R7: with nothing pending in the previous cycle the request is low
    quiet_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q) == '0) |-> !irq_req);

    // R7: a fully set mask in the previous cycle keeps the request low
    full_mask_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(mask_q)) |-> !irq_req);

endmodule

// File: tb/tb_edge_irq_ctrl.sv
// Bench for edge_irq_ctrl: sweeps every input with expected values
// computed from the requirements.
module tb_edge_irq_ctrl;

    localparam int unsigned N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    edge_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_in    (irq_in),
        .irq_req   (irq_req)
    );

    // Advance one edge and settle 5 ns after it
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        reg_addr = a;
        reg_we   = 1'b0;
        tick();
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic pulse(input int i);
        irq_in[i] = 1'b1;
        repeat (4) tick();
        irq_in[i] = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        logic [N-1:0] bi;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 irq", {15'b0, irq_req}, 16'h0);
        rd(4'h2, d); chk("R1 pending", d, 16'h0000);
        rd(4'hA, d); chk("R1 mask", d, 16'hFFFF);

        // R2 mask readback under several patterns
        wr(4'hA, 16'h0700); rd(4'hA, d); chk("R2 mask 0700", d, 16'h0700);
        wr(4'hA, 16'hA5C3); rd(4'hA, d); chk("R2 mask A5C3", d, 16'hA5C3);
        wr(4'hA, 16'hFFFF); rd(4'hA, d); chk("R2 mask FFFF", d, 16'hFFFF);

        // Sweep each input: R3 R4 R5 R7
        for (int i = 0; i < N; i++) begin
            bi = 16'(1) << i;
            pulse(i);
            rd(4'h2, d); chk("R3 R4 pending after pulse", d, bi);
            chk("R7 masked no request", {15'b0, irq_req}, 16'h0);
            wr(4'hA, bi);
            tick(); chk("R7 own bit masked", {15'b0, irq_req}, 16'h0);
            wr(4'hA, ~bi);
            chk("R7 request registered", {15'b0, irq_req}, 16'h0);
            tick(); chk("R7 request raised", {15'b0, irq_req}, 16'h1);
            wr(4'h2, 16'hFFFF);
            rd(4'h2, d); chk("R5 ones keep", d, bi);
            wr(4'h2, ~bi);
            rd(4'h2, d); chk("R5 zero clears", d, 16'h0);
            tick(); chk("R7 request dropped", {15'b0, irq_req}, 16'h0);
            wr(4'hA, 16'hFFFF);
        end

        // R4 held level does not re-set after clear
        irq_in[7] = 1'b1;
        repeat (4) tick();
        rd(4'h2, d); chk("R4 edge sets", d, 16'h0080);
        wr(4'h2, 16'h0000);
        repeat (6) tick();
        rd(4'h2, d); chk("R4 level ignored", d, 16'h0000);
        irq_in[7] = 1'b0;
        repeat (6) tick();
        rd(4'h2, d); chk("R4 fall ignored", d, 16'h0000);

        // R6 edge coincides with clear
        pulse(3);
        pulse(5);
        rd(4'h2, d); chk("R6 setup", d, 16'h0028);
        irq_in[3] = 1'b1;
        tick();
        tick();
        reg_addr  = 4'h2;
        reg_wdata = ~16'h0028;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
        rd(4'h2, d); chk("R6 edge wins", d, 16'h0008);
        irq_in[3] = 1'b0;
        repeat (4) tick();

        // R8 unmapped addresses: reads zero, writes ignored
        wr(4'hA, 16'h1234);
        for (int a = 0; a < 16; a++) begin
            if (a != 2 && a != 10) begin
                wr(4'(a), 16'h0000);
                rd(4'(a), d); chk("R8 unmapped read", d, 16'h0000);
            end
        end
        rd(4'hA, d); chk("R8 mask untouched", d, 16'h1234);
        rd(4'h2, d); chk("R8 pending untouched", d, 16'h0008);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule